// File: doc/BRIEF.md
# Replay-capable two-packet transmit byte queue

This block is a circular byte store that sits between a processor-side write port and the read port of a USB serial engine. Firmware writes the bytes of one or two outgoing packets and pushes the length of each packet into a two-entry length queue. The serial engine pulls bytes one at a time. Reads return data one cycle later, with a valid strobe.

The block tracks three positions: a write pointer, a read pointer and a commit marker. The marker holds the first byte of the packet now being sent. When a transfer succeeds, a commit moves the marker up to the read pointer. This frees the space and pops the head length. When a transfer fails, a rewind moves the read pointer back to the marker, so the same packet can be read out again.

A commit or rewind can come from an explicit firmware strobe. It can also come from the transfer-status strobe when the matching automatic-mode input is set. Fullness is measured from the marker, so bytes that have been read but not yet committed can never be overwritten.

Top module: `txq_fifo`

## Requirements
- R1: After a synchronous reset, `empty`=1, `full`=0, `rd_valid`=0, `len_count`=0, `len_head`=0 and `len_ovf`=0.
- R2: An accepted write stores `wr_data` and the write position then moves on by one. An accepted read (`rd_en` while `empty`=0 and no rewind) presents the byte at the read position on `rd_data`, with `rd_valid`=1, in the next cycle. Bytes come out in the order they were written.
- R3: `rd_en` while `empty`=1 is ignored: `rd_valid` is 0 in the next cycle and the read position does not move.
- R4: `full` is 1 exactly when the write position is DEPTH bytes ahead of the commit marker. A write while `full`=1 is ignored, and no stored byte changes.
- R5: A commit, caused by `cmd_commit`=1 or by `tx_done`=1 with `tx_good`=1 while `auto_commit`=1, moves the marker to the current read position. This frees the space of the committed bytes and pops the head entry of the length queue.
- R6: A rewind, caused by `cmd_rewind`=1 or by `tx_done`=1 with `tx_good`=0 while `auto_rewind`=1, sets the read position to the marker. Any `rd_en` in the same cycle is ignored. The bytes since the marker are then read again in the same order, and the length queue is unchanged.
- R7: `tx_done` has no effect on the pointers or the length queue when the automatic bit for its status (`auto_commit` for good, `auto_rewind` for bad) is 0.
- R8: When a commit and a rewind are requested in the same cycle, only the commit takes place.
- R9: The length queue holds up to two entries. `len_count` (0..2) gives the number of entries held. `len_head` gives the oldest entry, or 0 when the queue is empty. A push and a pop in the same cycle are both applied, the pop first.
- R10: A push while two entries are held and no pop occurs is discarded and sets `len_ovf`, which stays 1 until reset.
- R11: `empty` is 1 exactly when every written byte has been read. Bytes that have been read but not committed still count toward `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the processor side |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Read strobe from the serial engine |
| rd_data | output | DATA_W | Byte read, registered |
| rd_valid | output | 1 | `rd_data` holds a byte from the previous cycle's read |
| full | output | 1 | No free space relative to the commit marker |
| empty | output | 1 | No unread byte |
| auto_commit | input | 1 | Commit automatically on good status |
| auto_rewind | input | 1 | Rewind automatically on bad status |
| cmd_commit | input | 1 | Explicit commit strobe |
| cmd_rewind | input | 1 | Explicit rewind strobe |
| tx_done | input | 1 | Transfer-status strobe |
| tx_good | input | 1 | Status qualifier: 1 good, 0 bad |
| len_push | input | 1 | Push a packet length |
| len_in | input | CNT_W | Length to push |
| len_head | output | CNT_W | Oldest pending length |
| len_count | output | 2 | Number of pending lengths |
| len_ovf | output | 1 | Sticky length-queue overflow |

## Verification
Directed corners come first: filling to exactly DEPTH, a write into a full store, reading past the last byte, draining while uncommitted, an explicit rewind with replay, a bad status with automatic rewind off, a commit and a rewind together, and three length pushes. These separate marker-based from read-based fullness, and replay from fresh data. Then seeded random traffic runs in four automatic-mode settings, with writes, reads, status strobes and pushes mixed. A bench reference model checks every output each cycle. The mode settings tell commit apart from rewind, and the random mixes exercise the wrap-around of all three pointers.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Resolved pointer action for one cycle; commit has priority.
  typedef struct packed {
    logic commit;
    logic rewind;
  } txq_evt_t;
endpackage

// File: rtl/txq_ram.sv
module txq_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvalid); // R3
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
  import txq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  txq_evt_t          evt,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] wr_ptr, rd_ptr, mark;
  logic [PTR_W-1:0] used, ahead;

  assign used    = wr_ptr - mark;
  assign ahead   = rd_ptr - mark;
  assign full    = used[ADDR_W];
  assign empty   = (rd_ptr == wr_ptr);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty && !evt.rewind;
  assign wr_addr = wr_ptr[ADDR_W-1:0];
  assign rd_addr = rd_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      mark   <= '0;
    end else begin
      if (wr_fire)    wr_ptr <= wr_ptr + 1'b1;
      if (evt.commit) mark   <= rd_ptr;
      if (evt.rewind)   rd_ptr <= mark;
      else if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    used <= DEPTH_P); // R4
  AST_FULL_HOLDS_WPTR: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req) |=> $stable(wr_ptr)); // R4
  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ahead <= used); // R11
  AST_COMMIT_MOVES_MARK: assert property (@(posedge clk) disable iff (rst)
    evt.commit |=> (mark == $past(rd_ptr))); // R5
  AST_REWIND_RESTORES: assert property (@(posedge clk) disable iff (rst)
    evt.rewind |=> (rd_ptr == $past(mark))); // R6
  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (empty && !evt.rewind) |=> $stable(rd_ptr)); // R3
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    !(evt.commit && evt.rewind)); // R8
endmodule

// File: rtl/txq_lenq.sv
module txq_lenq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [CNT_W-1:0] len_in,
  input  logic             pop,
  output logic [CNT_W-1:0] head,
  output logic [1:0]       count,
  output logic             ovf
);
  logic [CNT_W-1:0] slot [2];
  logic             do_pop, lost;

  assign do_pop = pop && (count != 2'd0);
  assign lost   = push && (count == 2'd2) && !do_pop;
  assign head   = (count != 2'd0) ? slot[0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= 2'd0;
      ovf     <= 1'b0;
      slot[0] <= '0;
      slot[1] <= '0;
    end else begin
      if (lost) ovf <= 1'b1;
      unique case ({do_pop, push && !lost})
        2'b10: begin
          slot[0] <= slot[1];
          count   <= count - 2'd1;
        end
        2'b01: begin
          if (count == 2'd0) slot[0] <= len_in;
          else               slot[1] <= len_in;
          count <= count + 2'd1;
        end
        2'b11: begin
          if (count == 2'd2) begin
            slot[0] <= slot[1];
            slot[1] <= len_in;
          end else begin
            slot[0] <= len_in;
          end
        end
        default: ;
      endcase
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= 2'd2); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R10
  AST_OVF_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count == 2'd2) |=> (ovf && count == 2'd2)); // R10
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty,
  input  logic              auto_commit,
  input  logic              auto_rewind,
  input  logic              cmd_commit,
  input  logic              cmd_rewind,
  input  logic              tx_done,
  input  logic              tx_good,
  input  logic              len_push,
  input  logic [CNT_W-1:0]  len_in,
  output logic [CNT_W-1:0]  len_head,
  output logic [1:0]        len_count,
  output logic              len_ovf
);
  txq_evt_t          evt;
  logic              want_commit, want_rewind;
  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign want_commit = cmd_commit || (auto_commit && tx_done && tx_good);
  assign want_rewind = cmd_rewind || (auto_rewind && tx_done && !tx_good);
  assign evt.commit  = want_commit;
  assign evt.rewind  = want_rewind && !want_commit;

  txq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en), .evt(evt),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .full(full), .empty(empty)
  );

  txq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_fire), .raddr(rd_addr), .rdata(rd_data), .rvalid(rd_valid)
  );

  txq_lenq #(.CNT_W(CNT_W)) u_lenq (
    .clk(clk), .rst(rst), .push(len_push), .len_in(len_in),
    .pop(evt.commit), .head(len_head), .count(len_count), .ovf(len_ovf)
  );

  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !cmd_commit && !cmd_rewind &&
     !(auto_commit && tx_good) && !(auto_rewind && !tx_good) && !len_push)
    |=> $stable(len_count)); // R7
endmodule

// File: tb/txq_fifo_test.sv
`timescale 1ns/1ps
module txq_fifo_test;
  localparam int DW = 8, AW = 4, CW = 5, DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, auto_commit = 0, auto_rewind = 0;
  logic cmd_commit = 0, cmd_rewind = 0, tx_done = 0, tx_good = 0, len_push = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] len_in = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, full, empty, len_ovf;
  logic [CW-1:0] len_head;
  logic [1:0] len_count;

  txq_fifo #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  string cur = "R1";

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic [4:0] m_wp = 0, m_rp = 0, m_mk = 0;
  logic [CW-1:0] m_q0 = 0, m_q1 = 0;
  int m_cnt = 0;
  logic m_ovf = 0, m_rv = 0;
  logic [DW-1:0] m_rd = 0;

  function automatic logic m_full(); return ((m_wp - m_mk) & 5'd31) == 5'd16; endfunction
  function automatic logic m_empty(); return m_rp == m_wp; endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic com, rew, wf, rf, pop;
    com = cmd_commit || (auto_commit && tx_done && tx_good);
    rew = !com && (cmd_rewind || (auto_rewind && tx_done && !tx_good));
    wf = wr_en && !m_full();
    rf = rd_en && !rew && !m_empty();
    m_rv = rf;
    if (rf) m_rd = m_mem[m_rp[3:0]];
    if (wf) m_mem[m_wp[3:0]] = wr_data;
    if (com) m_mk = m_rp;
    if (rew) m_rp = m_mk; else if (rf) m_rp = m_rp + 5'd1;
    if (wf) m_wp = m_wp + 5'd1;
    pop = com && m_cnt > 0;
    if (pop) begin m_q0 = m_q1; m_cnt--; end
    if (len_push) begin
      if (m_cnt == 2) m_ovf = 1;
      else if (m_cnt == 1) begin m_q1 = len_in; m_cnt++; end
      else begin m_q0 = len_in; m_cnt++; end
    end
  endtask

  task automatic compare();
    chk("full(R4)", full, m_full());
    chk("empty(R11)", empty, m_empty());
    chk("rd_valid(R3)", rd_valid, m_rv);
    if (m_rv) chk("rd_data(R2)", rd_data, m_rd);
    chk("len_count(R9)", len_count, m_cnt);
    chk("len_head(R9)", len_head, m_cnt > 0 ? m_q0 : 0);
    chk("len_ovf(R10)", len_ovf, m_ovf);
  endtask

  task automatic step();
    model_step();
    @(posedge clk); #2;
    compare();
    {wr_en, rd_en, cmd_commit, cmd_rewind, tx_done, len_push} = '0;
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    cur = "R1";
    chk("empty", empty, 1); chk("full", full, 0); chk("rd_valid", rd_valid, 0);
    chk("len_count", len_count, 0); chk("len_head", len_head, 0); chk("len_ovf", len_ovf, 0);

    cur = "R3";
    rd_en = 1; step();
    cur = "R4";
    for (int i = 0; i < DEPTH; i++) begin wr_en = 1; wr_data = DW'(i + 8'h30); step(); end
    chk("full after DEPTH writes", full, 1);
    wr_en = 1; wr_data = 8'hEE; step();
    cur = "R11";
    for (int i = 0; i < DEPTH; i++) begin rd_en = 1; step(); end
    chk("full while uncommitted", full, 1);
    chk("empty after drain", empty, 1);
    cur = "R7";
    tx_done = 1; tx_good = 0; step();
    chk("empty unchanged", empty, 1);
    cur = "R6";
    cmd_rewind = 1; rd_en = 1; step();
    chk("empty after rewind", empty, 0);
    for (int i = 0; i < 4; i++) begin rd_en = 1; step(); end
    cur = "R9";
    len_push = 1; len_in = 5'd16; step();
    len_push = 1; len_in = 5'd3; step();
    cur = "R10";
    len_push = 1; len_in = 5'd7; step();
    chk("len_ovf set", len_ovf, 1);
    cur = "R8";
    cmd_commit = 1; cmd_rewind = 1; step();
    chk("full freed by commit", full, 0);
    cur = "R5";
    auto_commit = 1; tx_done = 1; tx_good = 1; step();

    for (int ph = 0; ph < 4; ph++) begin
      auto_commit = ph[0]; auto_rewind = ph[1];
      cur = (ph == 0) ? "R2" : (ph == 1) ? "R5" : (ph == 2) ? "R6" : "R9";
      for (int n = 0; n < 2500; n++) begin
        wr_en = ($urandom % 2) == 0;
        wr_data = DW'($urandom);
        rd_en = ($urandom % 5) < 2;
        tx_done = ($urandom % 20) == 0;
        tx_good = $urandom % 2;
        cmd_commit = ($urandom % 50) == 0;
        cmd_rewind = ($urandom % 50) == 0;
        len_push = ($urandom % 25) == 0;
        len_in = CW'($urandom);
        step();
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule